// File: doc/BRIEF.md
# Instruction Cycle Micro-Operation Sequencer

This block is the control unit and datapath of a small processor with one general register. It moves data among five registers (program counter, memory address register, memory buffer register, instruction register and the general register R) one register transfer per clock, which is one time unit. A 2-bit cycle code records which major cycle the machine is in: fetch, indirect, execute or interrupt. Where two transfers do not conflict, they share one time unit.

The block talks to a single-port memory. The address always comes from the memory address register. Write data always comes from the memory buffer register. Read data is combinational and is captured at the end of the same time unit.

The 16-bit instruction word holds the opcode in bits 15:13, an indirect flag in bit 12 and a 12-bit address in bits 11:0. The machine supports three instructions: add-from-memory, store, and increment-and-skip-if-zero. It also supports indirect operand addressing and entry into an interrupt handler.

Top module: `opseq_core`

## Requirements
- R1: A synchronous reset sets the cycle code to 00 (fetch) and clears PC, R and the interrupt enable. Fetching then starts at address 0 and nothing is written during reset.
- R2: The cycle code is encoded 00 fetch, 01 indirect, 10 execute, 11 interrupt. Fetch lasts three time units:
  - t1: MAR takes PC.
  - t2: MBR takes the memory word and PC advances by one.
  - t3: IR takes MBR.
  - Next, the code becomes 01 if bit 12 of the fetched word is 1, and 10 if it is 0.
- R3: mem_addr always shows MAR and mem_wdata always shows MBR. mem_we is asserted only in the store and increment-and-skip write units and in the second interrupt unit.
- R4: The indirect cycle lasts three units:
  - MAR takes the IR address field.
  - MBR takes memory.
  - The IR address field (bits 11:0) is replaced by bits 11:0 of MBR.
  - The next cycle is always execute.
- R5: Opcode 001 (add) executes in three units and leaves R = R + M[address], modulo 2^16.
- R6: Opcode 011 (store) executes in three units and writes R to M[address].
- R7: Opcode 010 (increment-and-skip) executes in four units and writes M[address]+1 back. In that same write unit, PC advances by one more when the written value is zero, which skips the next instruction. Otherwise PC is unchanged.
- R8: Any other opcode executes in one unit and changes neither R nor memory.
- R9: The interrupt cycle starts when, at the end of execute, irq is high and the interrupt enable is set. It lasts three units:
  - The return PC is saved to address 0.
  - PC is loaded with 1.
  - The enable is cleared.
  - Fetch always follows.
- R10: A one-clock pulse on ie_set sets the interrupt enable. When irq is low or the enable is clear at the end of execute, the next cycle is fetch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one period is one time unit |
| rst | input | 1 | Synchronous active-high reset |
| irq | input | 1 | Level interrupt request |
| ie_set | input | 1 | Pulse that sets the interrupt enable |
| mem_rdata | input | 16 | Combinational read data for mem_addr |
| mem_addr | output | 12 | Memory address (MAR) |
| mem_wdata | output | 16 | Memory write data (MBR) |
| mem_we | output | 1 | Memory write enable for this time unit |
| cyc_code | output | 2 | Current major-cycle code |
| pc_out | output | 12 | Program counter |
| acc_out | output | 16 | General register R |
| ie_out | output | 1 | Interrupt enable state |

## Verification
The assertions assume that mem_rdata is valid for the current mem_addr within the same time unit, and that a write with mem_we takes effect at that clock edge. They also assume that irq is a level that only counts when it is sampled at the final unit of execute. The bench uses a zero-latency memory model that writes on the clock edge. It keeps irq constant across whole instructions and pulses ie_set only during a fetch, so every cycle-code change and every memory effect lands on a time unit that can be predicted from the requirement tables alone.

// File: rtl/opseq_pkg.sv
package opseq_pkg;

  localparam int unsigned OPW = 3;

  typedef enum logic [1:0] {
    CYC_FETCH = 2'b00,
    CYC_IND   = 2'b01,
    CYC_EXEC  = 2'b10,
    CYC_INTR  = 2'b11
  } cyc_e;

  localparam logic [OPW-1:0] OP_ADD   = 3'b001;
  localparam logic [OPW-1:0] OP_ISZ   = 3'b010;
  localparam logic [OPW-1:0] OP_STORE = 3'b011;

  // one strobe per elementary register transfer
  typedef struct packed {
    logic mar_from_pc;
    logic mar_from_ir;
    logic mar_save;
    logic mbr_from_mem;
    logic mbr_from_pc;
    logic mbr_from_r;
    logic mbr_inc;
    logic ir_load;
    logic ir_addr_fix;
    logic pc_inc;
    logic pc_skip_chk;
    logic pc_handler;
    logic r_add;
    logic mem_we;
    logic ie_clr;
  } uop_t;

  // index of the final time unit of a major cycle
  function automatic logic [1:0] final_unit(cyc_e c, logic [OPW-1:0] op);
    logic [1:0] f;
    f = 2'd2;
    if (c == CYC_EXEC) begin
      if (op == OP_ISZ) f = 2'd3;
      else if (op == OP_ADD || op == OP_STORE) f = 2'd2;
      else f = 2'd0;
    end
    return f;
  endfunction

endpackage

// File: rtl/opseq_ctrl.sv
module opseq_ctrl
  import opseq_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           irq,
  input  logic           ie_set,
  input  logic [OPW-1:0] opcode,
  input  logic           fetched_ind,
  output cyc_e           code,
  output uop_t           uop,
  output logic           ie_q
);

  cyc_e       code_q, code_d;
  logic [1:0] unit_q;
  logic       unit_last;
  logic       irq_take;

  assign unit_last = (unit_q == final_unit(code_q, opcode));
  assign irq_take  = irq && ie_q;
  assign code      = code_q;

  always_comb begin
    uop = '0;
    unique case (code_q)
      CYC_FETCH: begin
        if (unit_q == 2'd0) uop.mar_from_pc = 1'b1;
        if (unit_q == 2'd1) begin
          uop.mbr_from_mem = 1'b1;
          uop.pc_inc       = 1'b1;
        end
        if (unit_q == 2'd2) uop.ir_load = 1'b1;
      end
      CYC_IND: begin
        if (unit_q == 2'd0) uop.mar_from_ir  = 1'b1;
        if (unit_q == 2'd1) uop.mbr_from_mem = 1'b1;
        if (unit_q == 2'd2) uop.ir_addr_fix  = 1'b1;
      end
      CYC_EXEC: begin
        if (opcode == OP_ADD) begin
          if (unit_q == 2'd0) uop.mar_from_ir  = 1'b1;
          if (unit_q == 2'd1) uop.mbr_from_mem = 1'b1;
          if (unit_q == 2'd2) uop.r_add        = 1'b1;
        end else if (opcode == OP_STORE) begin
          if (unit_q == 2'd0) uop.mar_from_ir = 1'b1;
          if (unit_q == 2'd1) uop.mbr_from_r  = 1'b1;
          if (unit_q == 2'd2) uop.mem_we      = 1'b1;
        end else if (opcode == OP_ISZ) begin
          if (unit_q == 2'd0) uop.mar_from_ir  = 1'b1;
          if (unit_q == 2'd1) uop.mbr_from_mem = 1'b1;
          if (unit_q == 2'd2) uop.mbr_inc      = 1'b1;
          if (unit_q == 2'd3) begin
            uop.mem_we      = 1'b1;
            uop.pc_skip_chk = 1'b1;
          end
        end
      end
      CYC_INTR: begin
        if (unit_q == 2'd0) begin
          uop.mbr_from_pc = 1'b1;
          uop.mar_save    = 1'b1;
        end
        if (unit_q == 2'd1) uop.mem_we = 1'b1;
        if (unit_q == 2'd2) begin
          uop.pc_handler = 1'b1;
          uop.ie_clr     = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_comb begin
    code_d = code_q;
    if (unit_last) begin
      unique case (code_q)
        CYC_FETCH: code_d = fetched_ind ? CYC_IND : CYC_EXEC;
        CYC_IND:   code_d = CYC_EXEC;
        CYC_EXEC:  code_d = irq_take ? CYC_INTR : CYC_FETCH;
        CYC_INTR:  code_d = CYC_FETCH;
        default:   code_d = CYC_FETCH;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= CYC_FETCH;
      unit_q <= 2'd0;
      ie_q   <= 1'b0;
    end else begin
      code_q <= code_d;
      unit_q <= unit_last ? 2'd0 : unit_q + 2'd1;
      if (uop.ie_clr) ie_q <= 1'b0;
      else if (ie_set) ie_q <= 1'b1;
    end
  end

  AST_FETCH_THREE_UNITS: assert property (@(posedge clk) disable iff (rst)
    (code_q != $past(code_q) && $past(code_q) == CYC_FETCH) |-> $past(unit_q) == 2'd2); // R2
  AST_IND_TO_EXEC: assert property (@(posedge clk) disable iff (rst)
    (code_q == CYC_IND && unit_last) |=> code_q == CYC_EXEC); // R4
  AST_INTR_TO_FETCH: assert property (@(posedge clk) disable iff (rst)
    (code_q == CYC_INTR && unit_last) |=> code_q == CYC_FETCH); // R9
  AST_INTR_CLEARS_EN: assert property (@(posedge clk) disable iff (rst)
    (code_q == CYC_INTR && unit_last) |=> !ie_q); // R9
  AST_MASKED_TO_FETCH: assert property (@(posedge clk) disable iff (rst)
    (code_q == CYC_EXEC && unit_last && !(irq && ie_q)) |=> code_q == CYC_FETCH); // R10

endmodule

// File: rtl/opseq_dp.sv
module opseq_dp
  import opseq_pkg::*;
#(
  parameter int unsigned DW        = 16,
  parameter int unsigned AW        = 12,
  parameter int unsigned ILEN      = 1,
  parameter int unsigned SAVE_ADDR = 0,
  parameter int unsigned HNDL_ADDR = 1
) (
  input  logic           clk,
  input  logic           rst,
  input  uop_t           uop,
  input  logic [DW-1:0]  mem_rdata,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  output logic [OPW-1:0] opcode,
  output logic           fetched_ind,
  output logic [AW-1:0]  pc,
  output logic [DW-1:0]  acc
);

  localparam int unsigned IND_BIT = AW;
  localparam int unsigned OP_LSB  = DW - OPW;

  logic [AW-1:0] pc_q, mar_q;
  logic [DW-1:0] mbr_q, ir_q, r_q;
  logic          skip_evt;

  function automatic logic [DW-1:0] word_add(logic [DW-1:0] a, logic [DW-1:0] b);
    return a + b;
  endfunction

  function automatic logic [DW-1:0] word_inc(logic [DW-1:0] a);
    return a + DW'(1);
  endfunction

  function automatic logic [AW-1:0] pc_step(logic [AW-1:0] p);
    return p + AW'(ILEN);
  endfunction

  assign skip_evt    = uop.pc_skip_chk && (mbr_q == '0);
  assign mem_addr    = mar_q;
  assign mem_wdata   = mbr_q;
  assign opcode      = ir_q[DW-1:OP_LSB];
  assign fetched_ind = mbr_q[IND_BIT];
  assign pc          = pc_q;
  assign acc         = r_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      mar_q <= '0;
      mbr_q <= '0;
      ir_q  <= '0;
      r_q   <= '0;
    end else begin
      if (uop.mar_from_pc) mar_q <= pc_q;
      if (uop.mar_from_ir) mar_q <= ir_q[AW-1:0];
      if (uop.mar_save)    mar_q <= AW'(SAVE_ADDR);

      if (uop.mbr_from_mem) mbr_q <= mem_rdata;
      if (uop.mbr_from_pc)  mbr_q <= DW'(pc_q);
      if (uop.mbr_from_r)   mbr_q <= r_q;
      if (uop.mbr_inc)      mbr_q <= word_inc(mbr_q);

      if (uop.ir_load)     ir_q <= mbr_q;
      if (uop.ir_addr_fix) ir_q[AW-1:0] <= mbr_q[AW-1:0];

      if (uop.pc_inc || skip_evt) pc_q <= pc_step(pc_q);
      if (uop.pc_handler)         pc_q <= AW'(HNDL_ADDR);

      if (uop.r_add) r_q <= word_add(r_q, mbr_q);
    end
  end

  AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    uop.pc_inc |=> pc_q == $past(pc_q) + AW'(ILEN)); // R2
  AST_IR_MADE_DIRECT: assert property (@(posedge clk) disable iff (rst)
    uop.ir_addr_fix |=> ir_q[AW-1:0] == $past(mbr_q[AW-1:0])); // R4
  AST_NO_SKIP_NONZERO: assert property (@(posedge clk) disable iff (rst)
    (uop.pc_skip_chk && mbr_q != '0) |=> pc_q == $past(pc_q)); // R7
  AST_ADD_RESULT: assert property (@(posedge clk) disable iff (rst)
    uop.r_add |=> r_q == $past(r_q) + $past(mbr_q)); // R5

endmodule

// File: rtl/opseq_core.sv
module opseq_core
  import opseq_pkg::*;
#(
  parameter int unsigned DW        = 16,
  parameter int unsigned AW        = 12,
  parameter int unsigned ILEN      = 1,
  parameter int unsigned SAVE_ADDR = 0,
  parameter int unsigned HNDL_ADDR = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          irq,
  input  logic          ie_set,
  input  logic [15:0]   mem_rdata,
  output logic [11:0]   mem_addr,
  output logic [15:0]   mem_wdata,
  output logic          mem_we,
  output logic [1:0]    cyc_code,
  output logic [11:0]   pc_out,
  output logic [15:0]   acc_out,
  output logic          ie_out
);

  uop_t           uop;
  cyc_e           code;
  logic [OPW-1:0] opcode;
  logic           fetched_ind;
  logic [AW-1:0]  addr_w, pc_w;
  logic [DW-1:0]  wdata_w, acc_w;

  opseq_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .irq         (irq),
    .ie_set      (ie_set),
    .opcode      (opcode),
    .fetched_ind (fetched_ind),
    .code        (code),
    .uop         (uop),
    .ie_q        (ie_out)
  );

  opseq_dp #(
    .DW        (DW),
    .AW        (AW),
    .ILEN      (ILEN),
    .SAVE_ADDR (SAVE_ADDR),
    .HNDL_ADDR (HNDL_ADDR)
  ) u_dp (
    .clk         (clk),
    .rst         (rst),
    .uop         (uop),
    .mem_rdata   (DW'(mem_rdata)),
    .mem_addr    (addr_w),
    .mem_wdata   (wdata_w),
    .opcode      (opcode),
    .fetched_ind (fetched_ind),
    .pc          (pc_w),
    .acc         (acc_w)
  );

  assign mem_addr  = 12'(addr_w);
  assign mem_wdata = 16'(wdata_w);
  assign pc_out    = 12'(pc_w);
  assign acc_out   = 16'(acc_w);
  assign mem_we    = uop.mem_we;
  assign cyc_code  = code;

  AST_WE_IN_SCOPE: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (cyc_code == 2'b10 || cyc_code == 2'b11)); // R3
  AST_RESET_STATE: assert property (@(posedge clk)
    $past(rst) |-> (cyc_code == 2'b00 && pc_out == '0 && acc_out == '0 && !ie_out)); // R1

endmodule

// File: tb/opseq_core_bench.sv
module opseq_core_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        irq = 1'b0;
  logic        ie_set = 1'b0;
  logic [15:0] mem_rdata;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_we;
  logic [1:0]  cyc_code;
  logic [11:0] pc_out;
  logic [15:0] acc_out;
  logic        ie_out;

  logic [15:0] mem [256];
  logic        ld_en = 1'b0;
  logic [7:0]  ld_addr = '0;
  logic [15:0] ld_data = '0;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  opseq_core u_opseq_core (
    .clk       (clk),
    .rst       (rst),
    .irq       (irq),
    .ie_set    (ie_set),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .cyc_code  (cyc_code),
    .pc_out    (pc_out),
    .acc_out   (acc_out),
    .ie_out    (ie_out)
  );

  assign mem_rdata = mem[mem_addr[7:0]];

  always @(posedge clk) begin
    if (ld_en) mem[ld_addr] <= ld_data;
    else if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic poke(logic [7:0] a, logic [15:0] d);
    ld_addr = a; ld_data = d; ld_en = 1'b1;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic hold_reset();
    rst = 1'b1; irq = 1'b0; ie_set = 1'b0;
    for (int i = 0; i < 256; i++) poke(8'(i), 16'h0000);
  endtask

  task automatic release_reset();
    @(negedge clk);
    rst = 1'b0;
  endtask

  // program: add direct, add indirect, store, skip taken, skip not taken
  task automatic t_program();
    hold_reset();
    poke(8'h00, 16'h2040);  // ADD 0x40
    poke(8'h01, 16'h3041);  // ADD @0x41
    poke(8'h02, 16'h6050);  // STORE 0x50
    poke(8'h03, 16'h4051);  // ISZ 0x51
    poke(8'h04, 16'h2040);  // ADD 0x40 (to be skipped)
    poke(8'h05, 16'h4052);  // ISZ 0x52
    poke(8'h06, 16'h2040);  // ADD 0x40
    poke(8'h07, 16'h6053);  // STORE 0x53
    poke(8'h08, 16'h0000);  // other opcode
    poke(8'h40, 16'h0005);
    poke(8'h41, 16'h0042);
    poke(8'h42, 16'h0007);
    poke(8'h51, 16'hFFFF);
    poke(8'h52, 16'h0003);
    check("R1 code in reset", 32'(cyc_code), 32'h0);
    check("R1 pc in reset", 32'(pc_out), 32'h0);
    check("R1 acc in reset", 32'(acc_out), 32'h0);
    check("R1 enable in reset", 32'(ie_out), 32'h0);
    check("R1 no write in reset", 32'(mem_we), 32'h0);
    release_reset();
    step(1);
    check("R3 mem_addr shows MAR=PC after t1", 32'(mem_addr), 32'h0);
    check("R2 fetch t1 code", 32'(cyc_code), 32'h0);
    step(1);
    check("R2 pc advanced in t2", 32'(pc_out), 32'h1);
    step(1);
    check("R2 direct fetch goes to execute", 32'(cyc_code), 32'h2);
    step(3);
    check("R5 add direct result", 32'(acc_out), 32'h5);
    check("R2 execute returns to fetch", 32'(cyc_code), 32'h0);
    step(3);
    check("R4 indirect flag goes to indirect", 32'(cyc_code), 32'h1);
    step(3);
    check("R4 indirect followed by execute", 32'(cyc_code), 32'h2);
    step(3);
    check("R4 add through pointer", 32'(acc_out), 32'd12);
    step(6);
    check("R6 store writes R", 32'(mem[8'h50]), 32'd12);
    step(7);
    check("R7 increment wraps to zero", 32'(mem[8'h51]), 32'h0);
    check("R7 zero result skips", 32'(pc_out), 32'h5);
    step(7);
    check("R7 nonzero increment", 32'(mem[8'h52]), 32'h4);
    check("R7 nonzero no skip", 32'(pc_out), 32'h6);
    step(6);
    check("R5 add after skip", 32'(acc_out), 32'd17);
    step(6);
    check("R6 second store", 32'(mem[8'h53]), 32'd17);
    step(3);
    check("R8 other opcode in execute", 32'(cyc_code), 32'h2);
    step(1);
    check("R8 one-unit execute", 32'(cyc_code), 32'h0);
    check("R8 R unchanged", 32'(acc_out), 32'd17);
    check("R8 pc", 32'(pc_out), 32'h9);
    check("R3 operand untouched", 32'(mem[8'h40]), 32'h5);
  endtask

  task automatic t_interrupt();
    hold_reset();
    poke(8'h00, 16'h2040);
    poke(8'h40, 16'h0009);
    irq = 1'b1;
    release_reset();
    step(6);
    check("R10 irq without enable goes to fetch", 32'(cyc_code), 32'h0);
    check("R10 enable still clear", 32'(ie_out), 32'h0);
    ie_set = 1'b1;
    step(1);
    ie_set = 1'b0;
    check("R10 ie_set pulse sets enable", 32'(ie_out), 32'h1);
    step(2);
    check("R9 executing at pc 2", 32'(cyc_code), 32'h2);
    step(1);
    check("R9 enabled irq enters interrupt", 32'(cyc_code), 32'h3);
    step(3);
    check("R9 interrupt followed by fetch", 32'(cyc_code), 32'h0);
    check("R9 pc loaded with handler", 32'(pc_out), 32'h1);
    check("R9 return pc saved at 0", 32'(mem[8'h00]), 32'h2);
    check("R9 enable cleared", 32'(ie_out), 32'h0);
    step(4);
    check("R10 masked irq after handler op", 32'(cyc_code), 32'h0);
    check("R10 pc after handler op", 32'(pc_out), 32'h2);
    irq = 1'b0;
  endtask

  initial begin
    t_program();
    t_interrupt();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule